// File: doc/BRIEF.md
# Iterative Carry-Save Fraction Multiplier

This block multiplies two unsigned N-bit fractions. It does not use one large array. A short stack of carry-save adder rows is used again and again. Each row adds either the multiplicand or zero, depending on one multiplier bit. The row then passes a sum vector and a carry vector on to the next row, shifted down by one place. The vectors that leave the last row are registered and fed back into the first row on the next clock. The array therefore finishes four multiplier bits per clock. Two clocks make up one microcycle, so each microcycle finishes eight bits.

A product bit drops out of the bottom of each row. That bit is exact, because the carry vector never reaches the lowest position. These bits are shifted into the top of the multiplier register as its used bits leave the bottom, so the register ends up holding the low half of the product. When the last pass is over, the block raises a one-cycle done pulse. It then presents three vectors: the redundant high half as a sum vector and a carry vector, and the exact low half. A downstream carry-propagate adder resolves the high half. In this project that adder exists only in the testbench.

Top module: `csa_iter_mul`

## Requirements
- R1: While reset is held and after it is released, busy_o and done_o are 0 and sum_o, carry_o and low_o are all zero.
- R2: A start_i seen high on a clock edge while busy_o is low captures both operands. From the next cycle busy_o is 1 and sum_o and carry_o read zero.
- R3: done_o rises exactly N/4 clock cycles after busy_o rises. That is N/8 microcycles of two clocks each. busy_o falls in the same cycle that done_o rises.
- R4: done_o is high for exactly one cycle per accepted start.
- R5: In the done cycle, (sum_o + carry_o) * 2^N + low_o equals the full 2N-bit unsigned product of the captured operands. This includes all-zero and all-ones operands.
- R6: A start_i while busy_o is high is ignored. The result and the done timing belong to the operation already running.
- R7: Each pass retires four multiplier bits, least significant first. After k passes, (sum_o + carry_o) * 2^(4k) + (low_o >> (N-4k)) equals the multiplicand times the low 4k bits of the multiplier.
- R8: While idle and without an accepted start, sum_o, carry_o and low_o hold their values from the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; accepted only when idle |
| mcand_i | input | N | Multiplicand, unsigned fraction |
| mplier_i | input | N | Multiplier, unsigned fraction |
| busy_o | output | 1 | Passes in progress |
| done_o | output | 1 | One-cycle pulse when the last pass completes |
| sum_o | output | N | Redundant high half, sum vector |
| carry_o | output | N | Redundant high half, carry vector |
| low_o | output | N | Exact low half of the product |

## Verification
The intermediate state in the middle of an operation is the hardest part to reach, because the ports only show it as a redundant pair of vectors and a register that mixes product bits with unused multiplier bits. To reach it, the monitor counts the passes since busy_o rose and checks the partial-product identity of R7 on every busy cycle, using the operands it pops from the scoreboard queue. The stimulus also issues a second start in the middle of an operation and a new start in the same cycle as done_o. These show that the operand registers ignore the first and accept the second.

// File: rtl/csa_mul_pkg.sv
package csa_mul_pkg;
  localparam int unsigned ROWS = 4;
  localparam int unsigned PASSES_PER_MC = 2;
  localparam int unsigned BITS_PER_MC = ROWS * PASSES_PER_MC;
endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  input  logic [W-1:0] mcand_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic [W-1:0] c_o,
  output logic         lsb_o
);
  logic [W-1:0] addend;
  logic [W-1:0] x;

  always_comb begin
    addend = sel_i ? mcand_i : '0;
    x      = s_i ^ c_i ^ addend;
    c_o    = (s_i & c_i) | (s_i & addend) | (c_i & addend);
    // sum shifts down one place; carry already has weight two
    s_o    = {1'b0, x[W-1:1]};
    lsb_o  = x[0];
  end
endmodule

// File: rtl/csa_array.sv
module csa_array #(
  parameter int unsigned W    = 32,
  parameter int unsigned ROWS = 4
) (
  input  logic [W-1:0]    s_i,
  input  logic [W-1:0]    c_i,
  input  logic [W-1:0]    mcand_i,
  input  logic [ROWS-1:0] sel_i,
  output logic [W-1:0]    s_o,
  output logic [W-1:0]    c_o,
  output logic [ROWS-1:0] drop_o
);
  logic [W-1:0] s_chain [ROWS+1];
  logic [W-1:0] c_chain [ROWS+1];

  assign s_chain[0] = s_i;
  assign c_chain[0] = c_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    csa_row #(.W(W)) u_row (
      .s_i     (s_chain[r]),
      .c_i     (c_chain[r]),
      .mcand_i (mcand_i),
      .sel_i   (sel_i[r]),
      .s_o     (s_chain[r+1]),
      .c_o     (c_chain[r+1]),
      .lsb_o   (drop_o[r])
    );
  end

  assign s_o = s_chain[ROWS];
  assign c_o = c_chain[ROWS];
endmodule

// File: rtl/csa_mul_ctrl.sv
module csa_mul_ctrl #(
  parameter int unsigned MC_COUNT      = 4,
  parameter int unsigned PASSES_PER_MC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned MC_W = (MC_COUNT > 1) ? $clog2(MC_COUNT) : 1;
  localparam int unsigned PH_W = (PASSES_PER_MC > 1) ? $clog2(PASSES_PER_MC) : 1;
  localparam logic [MC_W-1:0] MC_LAST = MC_W'(MC_COUNT - 1);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PASSES_PER_MC - 1);

  logic [MC_W-1:0] mc_q;
  logic [PH_W-1:0] ph_q;
  logic            last_pass;

  assign last_pass = (mc_q == MC_LAST) && (ph_q == PH_LAST);
  assign load_o    = start_i && !busy_o;
  assign step_o    = busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      mc_q   <= '0;
      ph_q   <= '0;
    end else begin
      done_o <= 1'b0;
      if (load_o) begin
        busy_o <= 1'b1;
        mc_q   <= '0;
        ph_q   <= '0;
      end else if (busy_o) begin
        if (last_pass) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else if (ph_q == PH_LAST) begin
          ph_q <= '0;
          mc_q <= mc_q + 1'b1;
        end else begin
          ph_q <= ph_q + 1'b1;
        end
      end
    end
  end

  // R3
  last_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && last_pass |=> done_o && !busy_o);

  // R4
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/csa_iter_mul.sv
module csa_iter_mul #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [N-1:0] mcand_i,
  input  logic [N-1:0] mplier_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [N-1:0] sum_o,
  output logic [N-1:0] carry_o,
  output logic [N-1:0] low_o
);
  import csa_mul_pkg::*;

  localparam int unsigned MC_COUNT = N / BITS_PER_MC;

  logic           load, step;
  logic [N-1:0]   mcand_q;
  logic [N-1:0]   s_q, c_q, mq_q;
  logic [N-1:0]   arr_s, arr_c;
  logic [ROWS-1:0] drop;

  csa_mul_ctrl #(
    .MC_COUNT      (MC_COUNT),
    .PASSES_PER_MC (PASSES_PER_MC)
  ) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  csa_array #(.W(N), .ROWS(ROWS)) u_array (
    .s_i     (s_q),
    .c_i     (c_q),
    .mcand_i (mcand_q),
    .sel_i   (mq_q[ROWS-1:0]),
    .s_o     (arr_s),
    .c_o     (arr_c),
    .drop_o  (drop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mcand_q <= '0;
      s_q     <= '0;
      c_q     <= '0;
      mq_q    <= '0;
    end else if (load) begin
      mcand_q <= mcand_i;
      s_q     <= '0;
      c_q     <= '0;
      mq_q    <= mplier_i;
    end else if (step) begin
      s_q  <= arr_s;
      c_q  <= arr_c;
      // product bits enter at the top as used multiplier bits leave
      mq_q <= {drop, mq_q[N-1:ROWS]};
    end
  end

  assign sum_o   = s_q;
  assign carry_o = c_q;
  assign low_o   = mq_q;

  // R2
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && sum_o == '0 && carry_o == '0);

  // R6
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(mcand_q));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !start_i |=> $stable(sum_o) && $stable(carry_o) && $stable(low_o));
endmodule

// File: tb/csa_iter_mul_tb.sv
module csa_iter_mul_tb;
  localparam int N = 32;
  localparam int P = N / 4;
  localparam int W2 = 2 * N + 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [N-1:0] mcand_i = '0;
  logic [N-1:0] mplier_i = '0;
  logic         busy_o, done_o;
  logic [N-1:0] sum_o, carry_o, low_o;

  int checks = 0;
  int errors = 0;

  logic [N-1:0] exp_a [$];
  logic [N-1:0] exp_b [$];
  logic [W2-1:0] last_prod;
  logic [N-1:0] hold_s, hold_c, hold_l;
  bit            have_hold = 0;
  bit            monitor_on = 0;
  int            k = 0;
  bit            prev_busy = 0, prev_done = 0;

  always #10 clk = ~clk;

  csa_iter_mul #(.N(N)) u_dut (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .mcand_i  (mcand_i),
    .mplier_i (mplier_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .sum_o    (sum_o),
    .carry_o  (carry_o),
    .low_o    (low_o)
  );

  task automatic check(input bit ok, input string req, input logic [W2-1:0] act,
                       input logic [W2-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W2-1:0] resolve();
    logic [W2-1:0] hi;
    hi = W2'(sum_o) + W2'(carry_o);
    return (hi << N) | W2'(low_o);
  endfunction

  // driver: pulse start and push the expected operands
  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b);
    @(negedge clk);
    start_i  = 1'b1;
    mcand_i  = a;
    mplier_i = b;
    exp_a.push_back(a);
    exp_b.push_back(b);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (monitor_on) begin
      if (busy_o && !prev_busy) k = 0;
      if (busy_o) begin
        logic [W2-1:0] part, ref_v, bmask;
        part  = ((W2'(sum_o) + W2'(carry_o)) << (4 * k)) + (W2'(low_o) >> (N - 4 * k));
        bmask = (W2'(1) << (4 * k)) - 1;
        ref_v = W2'(exp_a[0]) * (W2'(exp_b[0]) & bmask);
        if (k == 0)
          check(sum_o == '0 && carry_o == '0, "R2 cleared vectors",
                W2'(sum_o | carry_o), '0);
        check(part == ref_v, "R7 partial product", part, ref_v);
        k++;
      end
      if (done_o) begin
        logic [W2-1:0] ref_p;
        check(k == P, "R3 done latency", W2'(k), W2'(P));
        check(!busy_o, "R3 busy falls with done", W2'(busy_o), '0);
        check(!prev_done, "R4 single-cycle done", W2'(prev_done), '0);
        ref_p = W2'(exp_a[0]) * W2'(exp_b[0]);
        last_prod = resolve();
        check(last_prod == ref_p, "R5 product", last_prod, ref_p);
        void'(exp_a.pop_front());
        void'(exp_b.pop_front());
        hold_s = sum_o; hold_c = carry_o; hold_l = low_o;
        have_hold = 1;
      end else if (!busy_o && have_hold) begin
        check(sum_o == hold_s && carry_o == hold_c && low_o == hold_l,
              "R8 idle hold", resolve(), (W2'(hold_s) + W2'(hold_c)) << N | W2'(hold_l));
      end
      prev_busy = busy_o;
      prev_done = done_o;
    end
  end

  function automatic logic [N-1:0] xs(input logic [N-1:0] x);
    logic [N-1:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [N-1:0] seed;
    repeat (2) @(negedge clk);
    // R1 during reset
    check(!busy_o && !done_o && sum_o == '0 && carry_o == '0 && low_o == '0,
          "R1 reset state", W2'(busy_o) | W2'(done_o) | W2'(low_o), '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && sum_o == '0 && carry_o == '0 && low_o == '0,
          "R1 after release", W2'(busy_o) | W2'(done_o) | W2'(low_o), '0);
    monitor_on = 1;

    drive('0, '0);            wait_done();
    drive('1, '1);            wait_done();
    drive(N'(1), '1);         wait_done();
    drive('1, N'(1));         wait_done();
    drive({(N/2){2'b10}}, {(N/2){2'b01}}); wait_done();
    drive(N'(1) << (N-1), N'(1) << (N-1)); wait_done();

    // R6: second start mid-operation is ignored
    drive(N'(32'hDEAD_BEEF), N'(32'h1234_5678));
    @(negedge clk);
    start_i = 1'b1; mcand_i = '1; mplier_i = '1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    @(negedge clk);
    check(last_prod == W2'(N'(32'hDEAD_BEEF)) * W2'(N'(32'h1234_5678)),
          "R6 ignored start", last_prod,
          W2'(N'(32'hDEAD_BEEF)) * W2'(N'(32'h1234_5678)));
    check(!busy_o, "R6 no extra operation", W2'(busy_o), '0);
    repeat (3) @(negedge clk);

    // back-to-back: new start issued in the done cycle
    seed = N'(32'h2545_F491);
    for (int i = 0; i < 12; i++) begin
      logic [N-1:0] a, b;
      seed = xs(seed); a = seed;
      seed = xs(seed); b = seed;
      drive(a, b);
      wait_done();
      start_i = 1'b1; mcand_i = b; mplier_i = a;
      exp_a.push_back(b); exp_b.push_back(a);
      @(negedge clk);
      start_i = 1'b0;
      wait_done();
    end
    repeat (4) @(negedge clk);
    check(exp_a.size() == 0, "R4 every start completed once",
          W2'(exp_a.size()), '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule